// File: doc/BRIEF.md
# Diminished-one modulo 2^n+1 adder

This block adds or subtracts two residues modulo 2^n+1 that are held in diminished-one form: a stored n-bit code `d` stands for the value `d+1`, so the values 1 through 2^n all fit in n bits. The datapath is a parallel-prefix adder whose carry out of the top position is complemented and fed back as the carry into bit 0. This inverted end-around carry supplies the implicit +1 that the diminished-one sum needs. It also folds the result back into range without a second addition.

Zero has no n-bit code in this form. When the true result is zero, the block raises a dedicated flag and drives the data output to all zeros. The operand inputs always carry non-zero values. In subtract mode the second operand is negated by bitwise complement before the addition. The output is purely combinational and is typically placed after a carry-save reduction stage or between pipeline registers of a residue-arithmetic datapath.

Top module: `dim1_modadd`

## Requirements
- R1: With `sub_en`=0 and A=`op_a`+1, B=`op_b`+1, when (A+B) mod (2^W+1) is non-zero, `sum_d` equals that residue minus one and `res_zero` is 0.
- R2: With `sub_en`=1, when (A-B) mod (2^W+1) is non-zero, `sum_d` equals that residue minus one and `res_zero` is 0.
- R3: With `sub_en`=0, when A+B equals 2^W+1, `res_zero` is 1 and `sum_d` is all zeros.
- R4: With `sub_en`=1, when `op_a` equals `op_b`, `res_zero` is 1 and `sum_d` is all zeros.
- R5: Subtracting `op_b` gives the same outputs as adding its bitwise complement `~op_b`.
- R6: The outputs follow a change of the inputs within the same clock period, with no register on the path.
- R7: An operand code of all ones (value 2^W, congruent to -1) added to `op_a` yields `op_a`-1, or the zero result when `op_a` is 0.
- R8: The same relations hold for W=4 and W=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand, diminished-one code (value = code+1) |
| op_b | input | W | Second operand, diminished-one code |
| sub_en | input | 1 | 0 selects A+B, 1 selects A-B |
| sum_d | output | W | Result, diminished-one code; all zeros when the result is zero |
| res_zero | output | 1 | High when the residue result is zero |

## Verification
The block holds no state, so an internal fault appears as a wrong code on `sum_d` or a wrong `res_zero` for some operand pair, and it shows in the same cycle those operands are applied. A broken prefix cell corrupts only the pairs whose carry passes through it. A fault in the recirculated carry shows up as an off-by-one error on every pair on one side of the wrap point, and a fault in zero detection shows up on the single sum that lands on the modulus. The bench therefore applies every operand pair in both modes at both widths, because no smaller set is sure to reach every carry path.

// File: rtl/dim1_pkg.sv
// Package: shared mode encoding and sizing helpers for the
// diminished-one modulo adder. Assumes widths of at least 2.
package dim1_pkg;

    // Operation selector carried on sub_en.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    // Number of Kogge-Stone combining levels for a given width.
    function automatic int prefix_levels(input int w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/dim1_operand_prep.sv
// Operand conditioning: selects B or its complement (diminished-one
// negation) and forms per-bit generate and propagate terms.
// Assumes op_a/op_b are valid diminished-one codes of non-zero values.
module dim1_operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_en,
    output logic [W-1:0] bit_g,
    output logic [W-1:0] bit_p
);
    import dim1_pkg::*;

    logic [W-1:0] b_eff;

    // Negate the second operand by complement when subtracting.
    always_comb begin
        b_eff = (op_mode_e'(sub_en) == OP_SUB) ? ~op_b : op_b;
    end

    // Per-bit carry generate and propagate.
    always_comb begin
        bit_g = op_a & b_eff;
        bit_p = op_a ^ b_eff;
    end

endmodule

// File: rtl/dim1_prefix_tree.sv
// Kogge-Stone prefix network: for every position i gives the group
// generate and group propagate of bits i..0. Assumes W >= 2.
module dim1_prefix_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] bit_g,
    input  logic [W-1:0] bit_p,
    output logic [W-1:0] grp_g,
    output logic [W-1:0] grp_p
);
    import dim1_pkg::*;

    localparam int LV = prefix_levels(W);

    logic [W-1:0] g_lv [0:LV];
    logic [W-1:0] p_lv [0:LV];

    assign g_lv[0] = bit_g;
    assign p_lv[0] = bit_p;

    genvar l, i;
    generate
        for (l = 0; l < LV; l++) begin : g_level
            localparam int DIST = 1 << l;
            for (i = 0; i < W; i++) begin : g_cell
                if (i >= DIST) begin : g_merge
                    // Black cell: merge with the group DIST positions below.
                    assign g_lv[l+1][i] = g_lv[l][i] | (p_lv[l][i] & g_lv[l][i-DIST]);
                    assign p_lv[l+1][i] = p_lv[l][i] & p_lv[l][i-DIST];
                end else begin : g_pass
                    // Group already reaches bit 0: pass through.
                    assign g_lv[l+1][i] = g_lv[l][i];
                    assign p_lv[l+1][i] = p_lv[l][i];
                end
            end
        end
    endgenerate

    assign grp_g = g_lv[LV];
    assign grp_p = p_lv[LV];

endmodule

// File: rtl/dim1_recirc_sum.sv
// Sum stage: complements the top carry, injects it at bit 0 through the
// prefix terms, and forms the sum bits and the zero-result flag.
// Assumes grp_g/grp_p come from a full prefix over bits i..0.
module dim1_recirc_sum #(
    parameter int W = 8
) (
    input  logic [W-1:0] bit_p,
    input  logic [W-1:0] grp_g,
    input  logic [W-1:0] grp_p,
    output logic [W-1:0] sum_d,
    output logic         res_zero
);
    logic         cin_inv;
    logic [W-1:0] carry;

    // Inverted end-around carry from the top group generate.
    always_comb begin
        cin_inv = ~grp_g[W-1];
    end

    // Carry into each position, including the recirculated carry.
    always_comb begin
        carry[0] = cin_inv;
        for (int k = 1; k < W; k++) begin
            carry[k] = grp_g[k-1] | (grp_p[k-1] & cin_inv);
        end
    end

    // Sum bits; all-propagate means the unshifted sum is 2^W-1 (result zero).
    always_comb begin
        sum_d    = bit_p ^ carry;
        res_zero = grp_p[W-1];
    end

endmodule

// File: rtl/dim1_modadd.sv
// Top: diminished-one modulo 2^W+1 adder/subtractor, combinational.
// Assumes both operand codes represent non-zero residues.
module dim1_modadd #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_en,
    output logic [W-1:0] sum_d,
    output logic         res_zero
);
    logic [W-1:0] bit_g, bit_p, grp_g, grp_p;

    dim1_operand_prep #(.W(W)) u_prep (
        .op_a   (op_a),
        .op_b   (op_b),
        .sub_en (sub_en),
        .bit_g  (bit_g),
        .bit_p  (bit_p)
    );

    dim1_prefix_tree #(.W(W)) u_tree (
        .bit_g (bit_g),
        .bit_p (bit_p),
        .grp_g (grp_g),
        .grp_p (grp_p)
    );

    dim1_recirc_sum #(.W(W)) u_sum (
        .bit_p    (bit_p),
        .grp_g    (grp_g),
        .grp_p    (grp_p),
        .sum_d    (sum_d),
        .res_zero (res_zero)
    );

endmodule

// File: rtl/dim1_modadd_chk.sv
// Checker: port-level relations of the modulo adder, bound to the top.
// Immediate assertions, since the block has no clock.
module dim1_modadd_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         sub_en,
    input logic [W-1:0] sum_d,
    input logic         res_zero
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    // Check output relations whenever the ports change.
    always_comb begin
        a_r3_zero_clears_data: assert (!res_zero || sum_d == '0);
        a_r4_equal_sub_zero:   assert (!(sub_en && op_a == op_b) || res_zero);
        a_r1_unit_a_increment: assert (!(!sub_en && op_a == '0 && op_b != ALL1)
                                       || (sum_d == op_b + ONE && !res_zero));
        a_r7_minus_one_add:    assert (!(!sub_en && op_b == ALL1 && op_a != '0)
                                       || (sum_d == op_a - ONE && !res_zero));
        a_r2_sub_unit:         assert (!(sub_en && op_b == '0 && op_a != '0)
                                       || (sum_d == op_a - ONE && !res_zero));
    end

endmodule

bind dim1_modadd dim1_modadd_chk #(.W(W)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_en   (sub_en),
    .sum_d    (sum_d),
    .res_zero (res_zero)
);

// File: tb/sim_dim1_modadd.sv
// Bench: exhaustive comparison against an integer modulo reference,
// for W=8 (u0) and W=4 (u1).
module sim_dim1_modadd;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0] a8, b8, s8;
    logic       sub8, z8;
    logic [3:0] a4, b4, s4;
    logic       sub4, z4;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dim1_modadd #(.W(8)) u0 (.op_a(a8), .op_b(b8), .sub_en(sub8), .sum_d(s8), .res_zero(z8));
    dim1_modadd #(.W(4)) u1 (.op_a(a4), .op_b(b4), .sub_en(sub4), .sum_d(s4), .res_zero(z4));

    // Integer reference: value = code + 1, modulus 2^w + 1.
    function automatic void ref_mod(input int w, input int a, input int b, input bit s,
                                    output int d, output bit z);
        int m, va, vb, r;
        m  = (1 << w) + 1;
        va = a + 1;
        vb = b + 1;
        r  = s ? ((va - vb + m) % m) : ((va + vb) % m);
        z  = (r == 0);
        d  = z ? 0 : r - 1;
    endfunction

    task automatic chk(input string tag, input int act_d, input bit act_z,
                       input int exp_d, input bit exp_z);
        n_run++;
        if (act_d != exp_d || act_z != exp_z) begin
            n_bad++;
            $display("FAIL %s: got sum=%0d zero=%0d, expected sum=%0d zero=%0d",
                     tag, act_d, act_z, exp_d, exp_z);
        end
    endtask

    function automatic string pick_tag(input int w, input int b, input bit s, input bit z);
        if (w == 4)                       return "R8";
        if (!s && b == (1 << w) - 1)      return "R7";
        if (s)                            return z ? "R4" : "R2";
        return z ? "R3" : "R1";
    endfunction

    // Stimulus and comparison.
    initial begin
        int ed;
        bit ez;
        a8 = '0; b8 = '0; sub8 = 1'b0;
        a4 = '0; b4 = '0; sub4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Initial inputs 0,0 add: 1+1=2 -> code 1.
        chk("R1 initial", s8, z8, 1, 1'b0);

        // Width 4, all pairs, both modes (R8).
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    a4 = 4'(a); b4 = 4'(b); sub4 = s[0];
                    @(negedge clk);
                    ref_mod(4, a, b, s[0], ed, ez);
                    chk(pick_tag(4, b, s[0], ez), s4, z4, ed, ez);
                end

        // Width 8, all pairs, both modes.
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++) begin
                    @(posedge clk);
                    a8 = 8'(a); b8 = 8'(b); sub8 = s[0];
                    @(negedge clk);
                    ref_mod(8, a, b, s[0], ed, ez);
                    chk(pick_tag(8, b, s[0], ez), s8, z8, ed, ez);
                    if (s == 1) begin
                        // R5: subtract equals add of the complement.
                        ref_mod(8, a, 255 - b, 1'b0, ed, ez);
                        chk("R5", s8, z8, ed, ez);
                    end
                end

        // R6: change inputs mid-period and sample before any clock edge.
        @(negedge clk);
        a8 = 8'd200; b8 = 8'd100; sub8 = 1'b0;
        #1;
        ref_mod(8, 200, 100, 1'b0, ed, ez);
        chk("R6", s8, z8, ed, ez);
        sub8 = 1'b1;
        #0.5;
        ref_mod(8, 200, 100, 1'b1, ed, ez);
        chk("R6", s8, z8, ed, ez);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule